// File: doc/BRIEF.md
# CPU exception entry sequencer

This block sits next to a small 32-bit processor core and carries out the entry into exception handling. It watches the reset and NMI pins, the decode-stage fault flags (address error, undefined opcode, delay-slot context, PC-writing instruction, trap request) and a pending interrupt with its priority level. It picks the single source that wins and then runs the matching memory sequence over a word-wide bus with a request/acknowledge handshake.

For a reset, the block reads the start PC and the start stack pointer from a fixed pair of vector words. It then clears the vector base and sets the SR interrupt mask to all ones. Whether the pair belongs to a power-on reset or a manual reset depends on the NMI level at the moment the reset pin is released. For every other exception, the block pushes SR and then PC below the current R15 and reads the handler address from the vector table, which is indexed from the vector base register. It then reports the new PC, SP, SR and vector base with a one-cycle done strobe. Only interrupt entries load the accepted priority level into the mask.

States: `ST_IDLE` (waits for a source), `ST_RVEC_PC` and `ST_RVEC_SP` (reset vector reads), `ST_PUSH_SR` and `ST_PUSH_PC` (stack writes), `ST_HVEC` (handler vector read) and `ST_DONE` (strobe). Transitions: IDLE→RVEC_PC on a reset release; IDLE→PUSH_SR on any other accepted source; RVEC_PC→RVEC_SP, RVEC_SP→DONE, PUSH_SR→PUSH_PC, PUSH_PC→HVEC and HVEC→DONE, each on bus acknowledge; DONE→IDLE always. A low reset pin forces IDLE from any state.

Top module: `exc_entry_seq`

## Requirements
- R1: A low-to-high change of `res_n` while `nmi` is 1 starts a power-on entry that reads word 0x00000000 and then word 0x00000004; `new_pc` takes the first read data and `new_sp` takes the second.
- R2: A low-to-high change of `res_n` while `nmi` is 0 starts a manual-reset entry that reads 0x00000008 and then 0x0000000C, and loads `new_pc` and `new_sp` the same way.
- R3: At the end of either reset entry, `new_vbr` is 0 and `new_sr` equals the `cur_sr` captured at entry with bits [7:4] (the interrupt mask) set to 1111.
- R4: A non-reset entry writes `cur_sr` to `cur_r15`-4, then writes `cur_pc` to `cur_r15`-8, then reads `cur_vbr`+4*vector. The default vector numbers are: address error 9, interrupt 64, illegal slot 6, general illegal 4, trap 32. At the end, `new_pc` is the read data, `new_sp` is `cur_r15`-8 and `new_vbr` is `cur_vbr`.
- R5: An interrupt entry sets `new_sr` bits [7:4] to `irq_lvl` and keeps the other bits of `cur_sr`. Every other non-reset entry returns `new_sr` equal to `cur_sr`.
- R6: While `addr_err` or `irq_req` is the highest pending source and `ex_idle` is 0, the block makes no bus access and accepts no lower source. The entry starts once `ex_idle` is 1.
- R7: `dec_undef` with `dec_slot` 0 selects the general illegal vector. With `dec_slot` 1, either `dec_undef` or `dec_pcwr` selects the illegal-slot vector.
- R8: `trap_req` selects the trap vector and starts without waiting for `ex_idle`.
- R9: When several sources are pending, the winner follows this order: reset release, address error, interrupt, illegal slot, general illegal, trap.
- R10: Each access keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until the cycle in which `bus_ack` is 1, and the next access starts only after that cycle.
- R11: `done` is high for exactly one cycle after the last access, with no bus request in that cycle. The `new_*` outputs keep their values after it.
- R12: While `res_n` is 0, `bus_req` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset pin, active low; its release starts a reset entry |
| nmi | input | 1 | NMI pin level, selects power-on or manual reset at release |
| ex_idle | input | 1 | Preceding instruction has finished executing |
| addr_err | input | 1 | Address error flagged at decode |
| irq_req | input | 1 | Accepted interrupt pending |
| irq_lvl | input | 4 | Priority level of the pending interrupt |
| dec_undef | input | 1 | Undefined opcode decoded |
| dec_slot | input | 1 | Decoded instruction sits in a delayed-branch slot |
| dec_pcwr | input | 1 | Decoded instruction rewrites PC |
| trap_req | input | 1 | Trap instruction executing |
| cur_pc | input | 32 | PC to save |
| cur_sr | input | 32 | SR to save |
| cur_r15 | input | 32 | Current stack pointer |
| cur_vbr | input | 32 | Current vector base |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the word |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access completes this cycle |
| new_pc | output | 32 | Handler or reset start address |
| new_sp | output | 32 | Stack pointer after entry |
| new_sr | output | 32 | Status register after entry |
| new_vbr | output | 32 | Vector base after entry |
| done | output | 1 | One-cycle completion strobe |

## Verification
The assertions check on every cycle the handshake hold rule, the single-cycle done strobe, the silence of the bus in reset, the read-only nature of reset entries, the wait on an unfinished instruction, and the mask values returned for reset and interrupt entries. Only the bench's scenarios can show that the right vector words and stack addresses are touched in the right order, that the winning source follows the priority order under random mixes of pending flags, and that the returned PC, SP and vector base match the read data and the captured register values.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_POR,
        CLS_MRST,
        CLS_ADDR,
        CLS_IRQ,
        CLS_SLOT,
        CLS_GILL,
        CLS_TRAP
    } exc_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RVEC_PC,
        ST_RVEC_SP,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_HVEC,
        ST_DONE
    } seq_state_e;

    function automatic logic cls_is_reset(exc_cls_e c);
        return (c == CLS_POR) || (c == CLS_MRST);
    endfunction

endpackage

// File: rtl/exc_rst_detect.sv
module exc_rst_detect (
    input  logic clk,
    input  logic res_n,
    input  logic nmi,
    output logic rst_rise,
    output logic rst_por
);

    logic res_seen_q;

    // Cleared asynchronously while the pin is low; first edge after release sets it.
    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            res_seen_q <= 1'b0;
        end else begin
            res_seen_q <= 1'b1;
        end
    end

    assign rst_rise = res_n & ~res_seen_q;
    assign rst_por  = nmi;

endmodule

// File: rtl/exc_src_classify.sv
module exc_src_classify
    import exc_pkg::*;
#(
    parameter int VEC_W        = 8,
    parameter int VEC_ADDR_ERR = 9,
    parameter int VEC_IRQ      = 64,
    parameter int VEC_SLOT_ILL = 6,
    parameter int VEC_GEN_ILL  = 4,
    parameter int VEC_TRAP     = 32
) (
    input  logic             rst_rise,
    input  logic             rst_por,
    input  logic             ex_idle,
    input  logic             addr_err,
    input  logic             irq_req,
    input  logic             dec_undef,
    input  logic             dec_slot,
    input  logic             dec_pcwr,
    input  logic             trap_req,
    output exc_cls_e         cls,
    output logic             start,
    output logic [VEC_W-1:0] vec
);

    logic slot_fault;
    logic gen_fault;

    assign slot_fault = dec_slot & (dec_undef | dec_pcwr);
    assign gen_fault  = dec_undef & ~dec_slot;

    // Fixed priority chain; a blocked higher source holds off all lower ones.
    always_comb begin
        cls   = CLS_NONE;
        start = 1'b0;
        if (rst_rise) begin
            cls   = rst_por ? CLS_POR : CLS_MRST;
            start = 1'b1;
        end else if (addr_err) begin
            cls   = CLS_ADDR;
            start = ex_idle;
        end else if (irq_req) begin
            cls   = CLS_IRQ;
            start = ex_idle;
        end else if (slot_fault) begin
            cls   = CLS_SLOT;
            start = 1'b1;
        end else if (gen_fault) begin
            cls   = CLS_GILL;
            start = 1'b1;
        end else if (trap_req) begin
            cls   = CLS_TRAP;
            start = 1'b1;
        end
    end

    always_comb begin
        unique case (cls)
            CLS_ADDR: vec = VEC_W'(VEC_ADDR_ERR);
            CLS_IRQ:  vec = VEC_W'(VEC_IRQ);
            CLS_SLOT: vec = VEC_W'(VEC_SLOT_ILL);
            CLS_GILL: vec = VEC_W'(VEC_GEN_ILL);
            CLS_TRAP: vec = VEC_W'(VEC_TRAP);
            default:  vec = '0;
        endcase
    end

endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
    import exc_pkg::*;
#(
    parameter int             DW        = 32,
    parameter int             VEC_W     = 8,
    parameter int             MASK_LSB  = 4,
    parameter int             MASK_W    = 4,
    parameter logic [DW-1:0]  POR_BASE  = '0,
    parameter logic [DW-1:0]  MRST_BASE = DW'(8)
) (
    input  logic              clk,
    input  logic              res_n,
    input  logic              start,
    input  exc_cls_e          cls,
    input  logic [VEC_W-1:0]  vec,
    input  logic [MASK_W-1:0] irq_lvl,
    input  logic [DW-1:0]     cur_pc,
    input  logic [DW-1:0]     cur_sr,
    input  logic [DW-1:0]     cur_r15,
    input  logic [DW-1:0]     cur_vbr,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic [DW-1:0]     new_pc,
    output logic [DW-1:0]     new_sp,
    output logic [DW-1:0]     new_sr,
    output logic [DW-1:0]     new_vbr,
    output logic              done,
    output exc_cls_e          cls_q,
    output logic [MASK_W-1:0] lvl_q
);

    localparam int            WORD_B   = DW / 8;
    localparam logic [DW-1:0] STEP     = DW'(WORD_B);
    localparam logic [DW-1:0] STEP2    = DW'(2 * WORD_B);
    localparam int            VPAD     = DW - VEC_W - 2;

    seq_state_e        st_q, st_d;
    logic [VEC_W-1:0]  vec_q;
    logic [DW-1:0]     pc_q, sr_q, sp_q, vbr_q;
    logic [DW-1:0]     rst_base;
    logic [DW-1:0]     vec_off;

    function automatic logic [DW-1:0] with_mask(logic [DW-1:0] s, logic [MASK_W-1:0] m);
        logic [DW-1:0] r;
        r = s;
        r[MASK_LSB +: MASK_W] = m;
        return r;
    endfunction

    assign rst_base = (cls_q == CLS_POR) ? POR_BASE : MRST_BASE;
    assign vec_off  = {{VPAD{1'b0}}, vec_q, 2'b00};

    // State register
    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d = cls_is_reset(cls) ? ST_RVEC_PC : ST_PUSH_SR;
                end
            end
            ST_RVEC_PC: if (bus_ack) st_d = ST_RVEC_SP;
            ST_RVEC_SP: if (bus_ack) st_d = ST_DONE;
            ST_PUSH_SR: if (bus_ack) st_d = ST_PUSH_PC;
            ST_PUSH_PC: if (bus_ack) st_d = ST_HVEC;
            ST_HVEC:    if (bus_ack) st_d = ST_DONE;
            ST_DONE:    st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // Bus and strobe outputs, decoded from the state
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RVEC_PC: begin
                bus_req  = 1'b1;
                bus_addr = rst_base;
            end
            ST_RVEC_SP: begin
                bus_req  = 1'b1;
                bus_addr = rst_base + STEP;
            end
            ST_PUSH_SR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sp_q - STEP;
                bus_wdata = sr_q;
            end
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sp_q - STEP2;
                bus_wdata = pc_q;
            end
            ST_HVEC: begin
                bus_req  = 1'b1;
                bus_addr = vbr_q + vec_off;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // Captured context and result registers
    always_ff @(posedge clk or negedge res_n) begin
        if (!res_n) begin
            cls_q   <= CLS_NONE;
            vec_q   <= '0;
            lvl_q   <= '0;
            pc_q    <= '0;
            sr_q    <= '0;
            sp_q    <= '0;
            vbr_q   <= '0;
            new_pc  <= '0;
            new_sp  <= '0;
            new_sr  <= '0;
            new_vbr <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cls_q <= cls;
                        vec_q <= vec;
                        lvl_q <= irq_lvl;
                        pc_q  <= cur_pc;
                        sr_q  <= cur_sr;
                        sp_q  <= cur_r15;
                        vbr_q <= cur_vbr;
                    end
                end
                ST_RVEC_PC: begin
                    if (bus_ack) new_pc <= bus_rdata;
                end
                ST_RVEC_SP: begin
                    if (bus_ack) begin
                        new_sp  <= bus_rdata;
                        new_vbr <= '0;
                        new_sr  <= with_mask(sr_q, '1);
                    end
                end
                ST_HVEC: begin
                    if (bus_ack) begin
                        new_pc  <= bus_rdata;
                        new_sp  <= sp_q - STEP2;
                        new_vbr <= vbr_q;
                        new_sr  <= (cls_q == CLS_IRQ) ? with_mask(sr_q, lvl_q) : sr_q;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int DW           = 32,
    parameter int VEC_W        = 8,
    parameter int MASK_LSB     = 4,
    parameter int MASK_W       = 4,
    parameter int VEC_ADDR_ERR = 9,
    parameter int VEC_IRQ      = 64,
    parameter int VEC_SLOT_ILL = 6,
    parameter int VEC_GEN_ILL  = 4,
    parameter int VEC_TRAP     = 32
) (
    input  logic              clk,
    input  logic              res_n,
    input  logic              nmi,
    input  logic              ex_idle,
    input  logic              addr_err,
    input  logic              irq_req,
    input  logic [MASK_W-1:0] irq_lvl,
    input  logic              dec_undef,
    input  logic              dec_slot,
    input  logic              dec_pcwr,
    input  logic              trap_req,
    input  logic [DW-1:0]     cur_pc,
    input  logic [DW-1:0]     cur_sr,
    input  logic [DW-1:0]     cur_r15,
    input  logic [DW-1:0]     cur_vbr,
    output logic              bus_req,
    output logic              bus_we,
    output logic [DW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ack,
    output logic [DW-1:0]     new_pc,
    output logic [DW-1:0]     new_sp,
    output logic [DW-1:0]     new_sr,
    output logic [DW-1:0]     new_vbr,
    output logic              done
);

    localparam logic [DW-1:0] POR_BASE  = '0;
    localparam logic [DW-1:0] MRST_BASE = DW'(2 * (DW / 8));

    logic              rst_rise;
    logic              rst_por;
    exc_cls_e          src_cls;
    logic              src_start;
    logic [VEC_W-1:0]  src_vec;
    exc_cls_e          cls_q;
    logic [MASK_W-1:0] lvl_q;

    exc_rst_detect u_rst (
        .clk      (clk),
        .res_n    (res_n),
        .nmi      (nmi),
        .rst_rise (rst_rise),
        .rst_por  (rst_por)
    );

    exc_src_classify #(
        .VEC_W        (VEC_W),
        .VEC_ADDR_ERR (VEC_ADDR_ERR),
        .VEC_IRQ      (VEC_IRQ),
        .VEC_SLOT_ILL (VEC_SLOT_ILL),
        .VEC_GEN_ILL  (VEC_GEN_ILL),
        .VEC_TRAP     (VEC_TRAP)
    ) u_cls (
        .rst_rise  (rst_rise),
        .rst_por   (rst_por),
        .ex_idle   (ex_idle),
        .addr_err  (addr_err),
        .irq_req   (irq_req),
        .dec_undef (dec_undef),
        .dec_slot  (dec_slot),
        .dec_pcwr  (dec_pcwr),
        .trap_req  (trap_req),
        .cls       (src_cls),
        .start     (src_start),
        .vec       (src_vec)
    );

    exc_seq_fsm #(
        .DW        (DW),
        .VEC_W     (VEC_W),
        .MASK_LSB  (MASK_LSB),
        .MASK_W    (MASK_W),
        .POR_BASE  (POR_BASE),
        .MRST_BASE (MRST_BASE)
    ) u_fsm (
        .clk       (clk),
        .res_n     (res_n),
        .start     (src_start),
        .cls       (src_cls),
        .vec       (src_vec),
        .irq_lvl   (irq_lvl),
        .cur_pc    (cur_pc),
        .cur_sr    (cur_sr),
        .cur_r15   (cur_r15),
        .cur_vbr   (cur_vbr),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .new_pc    (new_pc),
        .new_sp    (new_sp),
        .new_sr    (new_sr),
        .new_vbr   (new_vbr),
        .done      (done),
        .cls_q     (cls_q),
        .lvl_q     (lvl_q)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MASK_LSB = 4,
    parameter int MASK_W   = 4
) (
    input logic              clk,
    input logic              res_n,
    input logic              ex_idle,
    input logic              addr_err,
    input logic              irq_req,
    input logic              bus_req,
    input logic              bus_we,
    input logic [DW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              bus_ack,
    input logic [DW-1:0]     new_sr,
    input logic [DW-1:0]     new_vbr,
    input logic              done,
    input logic              rst_rise,
    input exc_cls_e          cls_q,
    input logic [MASK_W-1:0] lvl_q
);

    logic [MASK_W-1:0] sr_mask;
    assign sr_mask = new_sr[MASK_LSB +: MASK_W];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!res_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!res_n)
        done |=> !done); // R11

    AST_DONE_NO_BUS: assert property (@(posedge clk) disable iff (!res_n)
        done |-> !bus_req); // R11

    AST_RST_READ_ONLY: assert property (@(posedge clk) disable iff (!res_n)
        bus_req && cls_is_reset(cls_q) |-> !bus_we); // R1

    AST_RST_RESULT: assert property (@(posedge clk) disable iff (!res_n)
        done && cls_is_reset(cls_q) |-> (new_vbr == '0) && (sr_mask == '1)); // R3

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!res_n)
        done && (cls_q == CLS_IRQ) |-> sr_mask == lvl_q); // R5

    AST_WAIT_EXEC: assert property (@(posedge clk) disable iff (!res_n)
        !bus_req && !done && !rst_rise && (addr_err || irq_req) && !ex_idle |=> !bus_req); // R6

    always_comb begin
        if (!res_n) begin
            AST_RESET_QUIET: assert (!bus_req && !done); // R12
        end
    end

endmodule

bind exc_entry_seq exc_entry_chk #(
    .DW       (DW),
    .MASK_LSB (MASK_LSB),
    .MASK_W   (MASK_W)
) u_chk (
    .clk       (clk),
    .res_n     (res_n),
    .ex_idle   (ex_idle),
    .addr_err  (addr_err),
    .irq_req   (irq_req),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .new_sr    (new_sr),
    .new_vbr   (new_vbr),
    .done      (done),
    .rst_rise  (rst_rise),
    .cls_q     (cls_q),
    .lvl_q     (lvl_q)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

    localparam int K_POR = 1, K_MRST = 2, K_ADDR = 3, K_IRQ = 4, K_SLOT = 5, K_GILL = 6, K_TRAP = 7;

    logic        clk = 1'b0;
    logic        res_n = 1'b0;
    logic        nmi = 1'b0, ex_idle = 1'b0, addr_err = 1'b0, irq_req = 1'b0;
    logic [3:0]  irq_lvl = '0;
    logic        dec_undef = 1'b0, dec_slot = 1'b0, dec_pcwr = 1'b0, trap_req = 1'b0;
    logic [31:0] cur_pc = '0, cur_sr = '0, cur_r15 = '0, cur_vbr = '0;
    logic        bus_req, bus_we, bus_ack = 1'b0, done;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [31:0] new_pc, new_sp, new_sr, new_vbr;

    int checks = 0;
    int failures = 0;
    int wait_cnt = 0;
    int log_n = 0;
    logic [31:0] log_addr [8];
    logic [31:0] log_data [8];
    logic        log_we   [8];

    always #5 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .res_n(res_n), .nmi(nmi), .ex_idle(ex_idle), .addr_err(addr_err),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .dec_undef(dec_undef), .dec_slot(dec_slot),
        .dec_pcwr(dec_pcwr), .trap_req(trap_req), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .cur_r15(cur_r15), .cur_vbr(cur_vbr), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .new_pc(new_pc), .new_sp(new_sp), .new_sr(new_sr), .new_vbr(new_vbr), .done(done)
    );

    function automatic logic [31:0] mem_f(logic [31:0] a);
        return (a * 32'h9E37_79B9) ^ 32'h0BAD_F00D;
    endfunction

    function automatic int exp_cls(bit ae, bit irq, bit slot, bit und, bit pcw, bit trp);
        if (ae) return K_ADDR;
        if (irq) return K_IRQ;
        if (slot && (und || pcw)) return K_SLOT;
        if (und && !slot) return K_GILL;
        if (trp) return K_TRAP;
        return 0;
    endfunction

    function automatic logic [31:0] vec_of(int c);
        case (c)
            K_ADDR:  return 32'd9;
            K_IRQ:   return 32'd64;
            K_SLOT:  return 32'd6;
            K_GILL:  return 32'd4;
            default: return 32'd32;
        endcase
    endfunction

    // Memory model: random wait, acknowledge driven at the falling edge, access logged there.
    always @(negedge clk) begin
        bus_ack = 1'b0;
        if (res_n && bus_req) begin
            if (wait_cnt == 0) begin
                bus_ack   = 1'b1;
                bus_rdata = mem_f(bus_addr);
                if (log_n < 8) begin
                    log_addr[log_n] = bus_addr;
                    log_data[log_n] = bus_wdata;
                    log_we[log_n]   = bus_we;
                end
                log_n++;
                wait_cnt = int'($urandom_range(2, 0));
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) return;
        end
        chk("R11 done timeout", 32'd0, 32'd1);
    endtask

    task automatic clear_flags();
        addr_err = 0; irq_req = 0; dec_undef = 0; dec_slot = 0; dec_pcwr = 0; trap_req = 0;
    endtask

    task automatic run_reset(input bit nmi_v);
        logic [31:0] base;
        @(negedge clk);
        res_n = 1'b0;
        nmi = nmi_v;
        cur_sr = $urandom();
        repeat (3) @(negedge clk);
        chk("R12 bus_req in reset", {31'd0, bus_req}, 32'd0);
        chk("R12 done in reset", {31'd0, done}, 32'd0);
        log_n = 0;
        res_n = 1'b1;
        wait_done();
        base = nmi_v ? 32'h0 : 32'h8;
        chk(nmi_v ? "R1 access count" : "R2 access count", log_n, 2);
        chk(nmi_v ? "R1 pc addr" : "R2 pc addr", log_addr[0], base);
        chk(nmi_v ? "R1 sp addr" : "R2 sp addr", log_addr[1], base + 4);
        chk(nmi_v ? "R1 new_pc" : "R2 new_pc", new_pc, mem_f(base));
        chk(nmi_v ? "R1 new_sp" : "R2 new_sp", new_sp, mem_f(base + 4));
        chk("R3 new_vbr", new_vbr, 32'h0);
        chk("R3 new_sr", new_sr, {cur_sr[31:8], 4'hF, cur_sr[3:0]});
        nmi = 1'b0;
        @(negedge clk);
        chk("R11 done one cycle", {31'd0, done}, 32'd0);
    endtask

    task automatic run_exc(input bit ae, input bit irq, input bit slot, input bit und,
                           input bit pcw, input bit trp, input logic [3:0] lvl, input bit stall);
        int c;
        logic [31:0] haddr, esr, xpc;
        c = exp_cls(ae, irq, slot, und, pcw, trp);
        @(negedge clk);
        cur_r15 = ($urandom() & 32'h0FFF_FFFC) | 32'h100;
        cur_vbr = ($urandom() & 32'h0FFF_FF00) | 32'h1000;
        cur_pc  = $urandom();
        cur_sr  = $urandom();
        irq_lvl = lvl;
        log_n = 0;
        addr_err = ae; irq_req = irq; dec_slot = slot; dec_undef = und; dec_pcwr = pcw; trap_req = trp;
        ex_idle = !stall;
        if (stall) begin
            repeat (5) @(negedge clk);
            chk("R6 no access while busy", log_n, 0);
            chk("R6 no done while busy", {31'd0, done}, 32'd0);
            ex_idle = 1'b1;
        end
        wait_done();
        clear_flags();
        haddr = cur_vbr + (vec_of(c) << 2);
        esr = (c == K_IRQ) ? {cur_sr[31:8], lvl, cur_sr[3:0]} : cur_sr;
        chk("R4 access count", log_n, 3);
        chk("R4 push sr addr", log_addr[0], cur_r15 - 4);
        chk("R4 push sr data", log_data[0], cur_sr);
        chk("R4 push sr we", {31'd0, log_we[0]}, 32'd1);
        chk("R4 push pc addr", log_addr[1], cur_r15 - 8);
        chk("R4 push pc data", log_data[1], cur_pc);
        chk("R9 R7 R8 vector addr", log_addr[2], haddr);
        chk("R4 vector read", {31'd0, log_we[2]}, 32'd0);
        chk("R4 new_pc", new_pc, mem_f(haddr));
        chk("R4 new_sp", new_sp, cur_r15 - 8);
        chk("R4 new_vbr", new_vbr, cur_vbr);
        chk("R5 new_sr", new_sr, esr);
        xpc = new_pc;
        @(negedge clk);
        chk("R11 done one cycle", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk("R11 new_pc held", new_pc, xpc);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired actual=running expected=finished");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none
    end

    initial begin
        void'($urandom(32'd7615));
        run_reset(1'b1);                                  // R1, R3, R12
        run_reset(1'b0);                                  // R2, R3
        run_exc(1, 0, 0, 0, 0, 0, 4'h0, 0);               // R4 address error
        run_exc(0, 1, 0, 0, 0, 0, 4'hA, 0);               // R5 interrupt level
        run_exc(0, 0, 0, 1, 0, 0, 4'h3, 0);               // R7 general illegal
        run_exc(0, 0, 1, 1, 0, 0, 4'h3, 0);               // R7 slot illegal
        run_exc(0, 0, 1, 0, 1, 0, 4'h3, 0);               // R7 PC write in slot
        run_exc(0, 0, 0, 0, 0, 1, 4'h3, 0);               // R8 trap
        run_exc(0, 0, 0, 0, 1, 1, 4'h3, 0);               // R7 PC write outside slot: trap wins
        run_exc(1, 0, 0, 0, 0, 1, 4'h0, 1);               // R6 address error waits, trap held off
        run_exc(0, 1, 1, 1, 0, 1, 4'h7, 1);               // R6 interrupt waits
        run_exc(1, 1, 1, 1, 1, 1, 4'h5, 0);               // R9 all pending
        for (int n = 0; n < 60; n++) begin
            bit b[6];
            for (int k = 0; k < 6; k++) b[k] = 1'($urandom_range(1, 0));
            if (exp_cls(b[0], b[1], b[2], b[3], b[4], b[5]) == 0) b[5] = 1'b1;
            run_exc(b[0], b[1], b[2], b[3], b[4], b[5], 4'($urandom_range(15, 0)),
                    1'($urandom_range(3, 0) == 0) && (b[0] || b[1]));   // R9 random mix
        end
        run_reset(1'b1);                                  // R1 again after traffic
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule